// File: doc/BRIEF.md
# Console Memory Management Unit

This block sits between an 8-bit console CPU, an object-memory DMA copier and the memories and peripherals of the console. Each master presents a 16-bit address, a read strobe, a write strobe and write data. The unit decodes the address and routes the access to one of three independent external buses: the main bus (cartridge ROM, cartridge RAM and work RAM), the video RAM bus, and the object attribute memory bus. Other addresses go to local resources: a boot ROM overlay, a high RAM, the I/O register port, and the interrupt flag and enable registers. The unit returns read data to each master on its own read-data line. There are no tri-states and no latches.

The DMA copier has fixed priority over the CPU on any bus it is using. A CPU access that loses a bus reads 0xFF, and a CPU write that loses is dropped. When the two masters use different buses, both accesses go ahead in the same cycle. Peripheral interrupt requests are latched into the flag register. The CPU sees an interrupt as pending only where the matching enable bit is also set.

Top module: `console_mmu`

## Requirements
- R1: After reset, a read of 0x0000–0x00FF by either master returns the boot byte, which is the low address byte XOR 0x3C (BOOT_KEY). Such a read raises no strobe on any external bus.
- R2: A CPU write of a nonzero value to 0xFF50 removes the boot overlay for good. A write of zero has no effect. After removal, 0x0000–0x00FF goes to the main bus, and only reset restores the overlay.
- R3: The main bus carries 0x0000–0x7FFF, 0xA000–0xBFFF and 0xC000–0xDFFF with the full 16-bit address. The video bus carries 0x8000–0x9FFF with address bits 12:0. The object bus carries 0xFE00–0xFE9F with address bits 7:0. A read returns that bus's read data.
- R4: An access to 0xE000–0xFDFF appears on the main bus at the address minus 0x2000.
- R5: 0xFF80–0xFFFE is a 127-byte high RAM that the CPU can read and write.
- R6: 0xFF00–0xFF7F, except 0xFF0F and 0xFF50, goes to the I/O port with address bits 6:0. A read returns io_rdata.
- R7: A read of 0xFEA0–0xFEFF returns 0xFF. A write there raises no strobe anywhere.
- R8: While the DMA master accesses a bus, that bus carries the DMA address, strobes and data. A CPU read of the same bus returns 0xFF and a CPU write to it is dropped. A CPU access to another bus proceeds in the same cycle.
- R9: The DMA master reaches only the three buses and the boot overlay. Any other DMA address raises no strobe, changes no state, and reads 0xFF.
- R10: The interrupt flag register is at 0xFF0F. It reads as 0b111 in bits 7:5, followed by the five flag bits. A 1 on irq_req[i] sets flag i on the next edge. A CPU write loads bits 4:0, but a request in the same cycle keeps its bit set.
- R11: The interrupt enable register is at 0xFFFF. It is an 8-bit read/write register that resets to 0x00.
- R12: irq_pending equals enable bits 4:0 AND the flag bits, as held after each clock edge. It is 0 after reset.
- R13: Read data appears on cpu_rdata or dma_rdata one cycle after the read. It holds until that master's next read, and both read-data lines reset to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, one cycle after the read |
| dma_addr | input | 16 | DMA address |
| dma_rd | input | 1 | DMA read strobe |
| dma_wr | input | 1 | DMA write strobe |
| dma_wdata | input | 8 | DMA write data |
| dma_rdata | output | 8 | DMA read data, one cycle after the read |
| main_addr | output | 16 | Main bus address |
| main_rd | output | 1 | Main bus read strobe |
| main_wr | output | 1 | Main bus write strobe |
| main_wdata | output | 8 | Main bus write data |
| main_rdata | input | 8 | Main bus read data |
| vram_addr | output | 13 | Video bus address |
| vram_rd | output | 1 | Video bus read strobe |
| vram_wr | output | 1 | Video bus write strobe |
| vram_wdata | output | 8 | Video bus write data |
| vram_rdata | input | 8 | Video bus read data |
| oam_addr | output | 8 | Object bus address |
| oam_rd | output | 1 | Object bus read strobe |
| oam_wr | output | 1 | Object bus write strobe |
| oam_wdata | output | 8 | Object bus write data |
| oam_rdata | input | 8 | Object bus read data |
| io_addr | output | 7 | I/O register offset |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| io_wdata | output | 8 | I/O write data |
| io_rdata | input | 8 | I/O read data |
| irq_req | input | 5 | Peripheral interrupt requests |
| irq_pending | output | 5 | Enabled and flagged interrupts |

## Verification
A decode fault shows in the same cycle as a strobe on the wrong bus or at the wrong address. A fault in the boot flag or a lost-bus read shows one cycle later as a wrong read byte. A flag or enable register that is wrong shows on irq_pending at the next edge. A high RAM fault stays hidden until the first read of the damaged byte, so the random phase reads high RAM often, against a model of its contents.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 8;
  localparam int VRAM_AW  = 13;
  localparam int OAM_AW   = 8;
  localparam int IO_AW    = 7;
  localparam int NBUS     = 3;
  localparam int BUS_MAIN = 0;
  localparam int BUS_VRAM = 1;
  localparam int BUS_OAM  = 2;

  localparam logic [ADDR_W-1:0] IFLAG_ADDR = 16'hFF0F;
  localparam logic [ADDR_W-1:0] BOOTX_ADDR = 16'hFF50;
  localparam logic [ADDR_W-1:0] IEN_ADDR   = 16'hFFFF;
  localparam logic [ADDR_W-1:0] ECHO_SHIFT = 16'h2000;

  typedef enum logic [3:0] {
    RG_NONE, RG_BOOT, RG_MAIN, RG_ECHO, RG_VRAM, RG_OAM,
    RG_IO, RG_IFLAG, RG_BOOTX, RG_HRAM, RG_IEN
  } region_e;

  // Address map; local_en=0 strips the regions a DMA master may not reach.
  function automatic region_e map_addr(input logic [ADDR_W-1:0] a,
                                       input logic boot_on,
                                       input logic local_en);
    region_e r;
    if (boot_on && a[15:8] == 8'h00) r = RG_BOOT;
    else if (a < 16'h8000)           r = RG_MAIN;
    else if (a < 16'hA000)           r = RG_VRAM;
    else if (a < 16'hE000)           r = RG_MAIN;
    else if (a < 16'hFE00)           r = RG_ECHO;
    else if (a < 16'hFEA0)           r = RG_OAM;
    else if (a < 16'hFF00)           r = RG_NONE;
    else if (a == IFLAG_ADDR)        r = RG_IFLAG;
    else if (a == BOOTX_ADDR)        r = RG_BOOTX;
    else if (a < 16'hFF80)           r = RG_IO;
    else if (a == IEN_ADDR)          r = RG_IEN;
    else                             r = RG_HRAM;
    if (!local_en && (r inside {RG_IO, RG_IFLAG, RG_BOOTX, RG_IEN, RG_HRAM}))
      r = RG_NONE;
    return r;
  endfunction
endpackage

// File: rtl/mmu_decode.sv
module mmu_decode
  import mmu_pkg::*;
#(
  parameter bit LOCAL_EN = 1'b1
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rd,
  input  logic               wr,
  input  logic               boot_on,
  output region_e            region,
  output logic [NBUS-1:0]    bus_req,
  output logic [ADDR_W-1:0]  main_a,
  output logic [VRAM_AW-1:0] vram_a,
  output logic [OAM_AW-1:0]  oam_a
);
  logic active;

  always_comb begin
    region = map_addr(addr, boot_on, LOCAL_EN);
    active = rd | wr;
    bus_req[BUS_MAIN] = active & (region == RG_MAIN || region == RG_ECHO);
    bus_req[BUS_VRAM] = active & (region == RG_VRAM);
    bus_req[BUS_OAM]  = active & (region == RG_OAM);
    main_a = (region == RG_ECHO) ? addr - ECHO_SHIFT : addr;
    vram_a = addr[VRAM_AW-1:0];
    oam_a  = addr[OAM_AW-1:0];
  end
endmodule

// File: rtl/mmu_arbiter.sv
module mmu_arbiter #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          dma_req,
  input  logic          dma_we,
  input  logic [AW-1:0] dma_addr,
  input  logic [DW-1:0] dma_wdata,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [DW-1:0] bus_wdata,
  output logic          cpu_grant,
  output logic          dma_grant
);
  // Fixed priority: the copier owns the bus whenever it asks for it.
  always_comb begin
    dma_grant = dma_req;
    cpu_grant = cpu_req & ~dma_req;
    if (dma_req) begin
      bus_addr  = dma_addr;
      bus_rd    = ~dma_we;
      bus_wr    = dma_we;
      bus_wdata = dma_wdata;
    end else begin
      bus_addr  = cpu_addr;
      bus_rd    = cpu_grant & ~cpu_we;
      bus_wr    = cpu_grant & cpu_we;
      bus_wdata = cpu_wdata;
    end
  end

  // R8
  one_master_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && dma_req) |-> (!cpu_grant && bus_wr == dma_we));
endmodule

// File: rtl/mmu_hram.sv
module mmu_hram #(
  parameter int DEPTH = 127,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/mmu_irq.sv
module mmu_irq #(
  parameter int N  = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  irq_req,
  input  logic          if_we,
  input  logic          ie_we,
  input  logic [DW-1:0] wdata,
  output logic [N-1:0]  if_q,
  output logic [DW-1:0] ie_q,
  output logic [N-1:0]  pending
);
  always_ff @(posedge clk) begin
    if (rst) begin
      if_q <= '0;
      ie_q <= '0;
    end else begin
      // A same-cycle request beats a clearing write.
      if (if_we) if_q <= wdata[N-1:0] | irq_req;
      else       if_q <= if_q | irq_req;
      if (ie_we) ie_q <= wdata;
    end
  end

  assign pending = ie_q[N-1:0] & if_q;

  // R10
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|irq_req) |=> ((if_q & $past(irq_req)) == $past(irq_req)));
endmodule

// File: rtl/console_mmu.sv
module console_mmu
  import mmu_pkg::*;
#(
  parameter logic [7:0] BOOT_KEY   = 8'h3C,
  parameter int         HRAM_DEPTH = 127,
  parameter int         IRQ_N      = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [15:0]        cpu_addr,
  input  logic               cpu_rd,
  input  logic               cpu_wr,
  input  logic [7:0]         cpu_wdata,
  output logic [7:0]         cpu_rdata,
  input  logic [15:0]        dma_addr,
  input  logic               dma_rd,
  input  logic               dma_wr,
  input  logic [7:0]         dma_wdata,
  output logic [7:0]         dma_rdata,
  output logic [15:0]        main_addr,
  output logic               main_rd,
  output logic               main_wr,
  output logic [7:0]         main_wdata,
  input  logic [7:0]         main_rdata,
  output logic [12:0]        vram_addr,
  output logic               vram_rd,
  output logic               vram_wr,
  output logic [7:0]         vram_wdata,
  input  logic [7:0]         vram_rdata,
  output logic [7:0]         oam_addr,
  output logic               oam_rd,
  output logic               oam_wr,
  output logic [7:0]         oam_wdata,
  input  logic [7:0]         oam_rdata,
  output logic [6:0]         io_addr,
  output logic               io_rd,
  output logic               io_wr,
  output logic [7:0]         io_wdata,
  input  logic [7:0]         io_rdata,
  input  logic [IRQ_N-1:0]   irq_req,
  output logic [IRQ_N-1:0]   irq_pending
);
  localparam int HRAM_AW = $clog2(HRAM_DEPTH + 1);

  logic boot_q;
  region_e cpu_region, dma_region;
  logic [NBUS-1:0] cpu_bus_req, dma_bus_req, cpu_gnt, dma_gnt;
  logic [ADDR_W-1:0]  cpu_main_a, dma_main_a;
  logic [VRAM_AW-1:0] cpu_vram_a, dma_vram_a;
  logic [OAM_AW-1:0]  cpu_oam_a, dma_oam_a;

  mmu_decode #(.LOCAL_EN(1'b1)) u_cpu_dec (
    .addr(cpu_addr), .rd(cpu_rd), .wr(cpu_wr), .boot_on(boot_q),
    .region(cpu_region), .bus_req(cpu_bus_req),
    .main_a(cpu_main_a), .vram_a(cpu_vram_a), .oam_a(cpu_oam_a));

  mmu_decode #(.LOCAL_EN(1'b0)) u_dma_dec (
    .addr(dma_addr), .rd(dma_rd), .wr(dma_wr), .boot_on(boot_q),
    .region(dma_region), .bus_req(dma_bus_req),
    .main_a(dma_main_a), .vram_a(dma_vram_a), .oam_a(dma_oam_a));

  mmu_arbiter #(.AW(ADDR_W), .DW(DATA_W)) u_arb_main (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_bus_req[BUS_MAIN]), .cpu_we(cpu_wr), .cpu_addr(cpu_main_a), .cpu_wdata(cpu_wdata),
    .dma_req(dma_bus_req[BUS_MAIN]), .dma_we(dma_wr), .dma_addr(dma_main_a), .dma_wdata(dma_wdata),
    .bus_addr(main_addr), .bus_rd(main_rd), .bus_wr(main_wr), .bus_wdata(main_wdata),
    .cpu_grant(cpu_gnt[BUS_MAIN]), .dma_grant(dma_gnt[BUS_MAIN]));

  mmu_arbiter #(.AW(VRAM_AW), .DW(DATA_W)) u_arb_vram (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_bus_req[BUS_VRAM]), .cpu_we(cpu_wr), .cpu_addr(cpu_vram_a), .cpu_wdata(cpu_wdata),
    .dma_req(dma_bus_req[BUS_VRAM]), .dma_we(dma_wr), .dma_addr(dma_vram_a), .dma_wdata(dma_wdata),
    .bus_addr(vram_addr), .bus_rd(vram_rd), .bus_wr(vram_wr), .bus_wdata(vram_wdata),
    .cpu_grant(cpu_gnt[BUS_VRAM]), .dma_grant(dma_gnt[BUS_VRAM]));

  mmu_arbiter #(.AW(OAM_AW), .DW(DATA_W)) u_arb_oam (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_bus_req[BUS_OAM]), .cpu_we(cpu_wr), .cpu_addr(cpu_oam_a), .cpu_wdata(cpu_wdata),
    .dma_req(dma_bus_req[BUS_OAM]), .dma_we(dma_wr), .dma_addr(dma_oam_a), .dma_wdata(dma_wdata),
    .bus_addr(oam_addr), .bus_rd(oam_rd), .bus_wr(oam_wr), .bus_wdata(oam_wdata),
    .cpu_grant(cpu_gnt[BUS_OAM]), .dma_grant(dma_gnt[BUS_OAM]));

  // Boot overlay flag: cleared by a nonzero write, set only by reset.
  always_ff @(posedge clk) begin
    if (rst) boot_q <= 1'b1;
    else if (cpu_wr && cpu_region == RG_BOOTX && cpu_wdata != '0) boot_q <= 1'b0;
  end

  // I/O port
  assign io_addr  = cpu_addr[IO_AW-1:0];
  assign io_rd    = cpu_rd & (cpu_region == RG_IO);
  assign io_wr    = cpu_wr & (cpu_region == RG_IO);
  assign io_wdata = cpu_wdata;

  // High RAM and interrupt registers
  logic [DATA_W-1:0] hram_q, ie_q;
  logic [IRQ_N-1:0]  if_q;

  mmu_hram #(.DEPTH(HRAM_DEPTH), .DW(DATA_W)) u_hram (
    .clk(clk),
    .we(cpu_wr & (cpu_region == RG_HRAM)),
    .re(cpu_rd & (cpu_region == RG_HRAM)),
    .addr(cpu_addr[HRAM_AW-1:0]), .wdata(cpu_wdata), .rdata(hram_q));

  mmu_irq #(.N(IRQ_N), .DW(DATA_W)) u_irq (
    .clk(clk), .rst(rst), .irq_req(irq_req),
    .if_we(cpu_wr & (cpu_region == RG_IFLAG)),
    .ie_we(cpu_wr & (cpu_region == RG_IEN)),
    .wdata(cpu_wdata), .if_q(if_q), .ie_q(ie_q), .pending(irq_pending));

  // Read value selection per master
  logic [DATA_W-1:0] boot_byte_c, boot_byte_d, cpu_val, dma_val, cpu_val_q, dma_val_q;
  logic cpu_hram_q;

  always_comb begin
    boot_byte_c = cpu_addr[7:0] ^ BOOT_KEY;
    boot_byte_d = dma_addr[7:0] ^ BOOT_KEY;
    case (cpu_region)
      RG_BOOT:         cpu_val = boot_byte_c;
      RG_MAIN, RG_ECHO: cpu_val = cpu_gnt[BUS_MAIN] ? main_rdata : 8'hFF;
      RG_VRAM:         cpu_val = cpu_gnt[BUS_VRAM] ? vram_rdata : 8'hFF;
      RG_OAM:          cpu_val = cpu_gnt[BUS_OAM]  ? oam_rdata  : 8'hFF;
      RG_IO:           cpu_val = io_rdata;
      RG_IFLAG:        cpu_val = {{(DATA_W-IRQ_N){1'b1}}, if_q};
      RG_IEN:          cpu_val = ie_q;
      default:         cpu_val = 8'hFF;
    endcase
    case (dma_region)
      RG_BOOT:         dma_val = boot_byte_d;
      RG_MAIN, RG_ECHO: dma_val = dma_gnt[BUS_MAIN] ? main_rdata : 8'hFF;
      RG_VRAM:         dma_val = dma_gnt[BUS_VRAM] ? vram_rdata : 8'hFF;
      RG_OAM:          dma_val = dma_gnt[BUS_OAM]  ? oam_rdata  : 8'hFF;
      default:         dma_val = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_val_q  <= 8'hFF;
      dma_val_q  <= 8'hFF;
      cpu_hram_q <= 1'b0;
    end else begin
      if (cpu_rd) begin
        cpu_val_q  <= cpu_val;
        cpu_hram_q <= (cpu_region == RG_HRAM);
      end
      if (dma_rd) dma_val_q <= dma_val;
    end
  end

  assign cpu_rdata = cpu_hram_q ? hram_q : cpu_val_q;
  assign dma_rdata = dma_val_q;

  // R2
  boot_stays_off_chk: assert property (@(posedge clk) disable iff (rst)
    !boot_q |=> !boot_q);

  // R8
  dma_priority_chk: assert property (@(posedge clk) disable iff (rst)
    dma_bus_req[BUS_VRAM] |-> (vram_wr == dma_wr && vram_rd == dma_rd && vram_wdata == dma_wdata));

  // R4
  echo_window_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr >= 16'hE000 && cpu_addr < 16'hFE00 && (cpu_rd || cpu_wr) && !dma_bus_req[BUS_MAIN])
      |-> (main_addr[12:0] == cpu_addr[12:0] && main_addr[15:13] == 3'b110));

  // R7
  unused_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr >= 16'hFEA0 && cpu_addr < 16'hFF00 && cpu_wr && dma_bus_req == '0)
      |-> !(main_wr || vram_wr || oam_wr || io_wr));

  // R13
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cpu_rd |=> $stable(cpu_rdata));
endmodule

// File: tb/test_console_mmu.sv
module test_console_mmu;
  logic clk = 1'b0;
  always #5 clk = ~clk;   // 10-unit period, 100 MHz nominal

  logic rst;
  logic [15:0] cpu_addr, dma_addr, main_addr;
  logic cpu_rd, cpu_wr, dma_rd, dma_wr;
  logic [7:0] cpu_wdata, cpu_rdata, dma_wdata, dma_rdata;
  logic main_rd, main_wr, vram_rd, vram_wr, oam_rd, oam_wr, io_rd, io_wr;
  logic [7:0] main_wdata, main_rdata, vram_wdata, vram_rdata, oam_addr, oam_wdata, oam_rdata;
  logic [7:0] io_wdata, io_rdata;
  logic [12:0] vram_addr;
  logic [6:0] io_addr;
  logic [4:0] irq_req, irq_pending;

  console_mmu i_console_mmu (.*);

  function automatic logic [7:0] main_f(input logic [15:0] a); return a[7:0] ^ a[15:8] ^ 8'h5A; endfunction
  function automatic logic [7:0] vram_f(input logic [12:0] a); return a[7:0] + {3'b0, a[12:8]} + 8'h21; endfunction
  function automatic logic [7:0] oam_f(input logic [7:0] a); return {a[3:0], a[7:4]} ^ 8'h0F; endfunction
  function automatic logic [7:0] io_f(input logic [6:0] a); return {1'b1, a} ^ 8'h33; endfunction

  always_comb main_rdata = main_f(main_addr);
  always_comb vram_rdata = vram_f(vram_addr);
  always_comb oam_rdata  = oam_f(oam_addr);
  always_comb io_rdata   = io_f(io_addr);

  int checks = 0, errors = 0;
  bit boot_m;
  logic [7:0] hram_m [128];
  logic [4:0] if_m;
  logic [7:0] ie_m, exp_c, exp_d;

  // 0 main, 1 video, 2 object, 3 local/none, 4 boot overlay
  function automatic int bus_of(input logic [15:0] a, input bit boot);
    if (boot && a < 16'h0100) return 4;
    if (a < 16'h8000) return 0;
    if (a < 16'hA000) return 1;
    if (a < 16'hFE00) return 0;
    if (a < 16'hFEA0) return 2;
    return 3;
  endfunction

  function automatic logic [15:0] xlat(input logic [15:0] a);
    if (a >= 16'hE000 && a < 16'hFE00) return a - 16'h2000;
    if (a >= 16'h8000 && a < 16'hA000) return a & 16'h1FFF;
    if (a >= 16'hFE00) return a & 16'h00FF;
    return a;
  endfunction

  function automatic logic [7:0] mem_f(input int b, input logic [15:0] a);
    if (b == 0) return main_f(a);
    if (b == 1) return vram_f(a[12:0]);
    return oam_f(a[7:0]);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] ca, input logic crd, input logic cwr, input logic [7:0] cwd,
                      input logic [15:0] da, input logic drd, input logic dwr, input logic [7:0] dwd,
                      input logic [4:0] irq, input string tag);
    int cb, db;
    bit is_io;
    cpu_addr = ca; cpu_rd = crd; cpu_wr = cwr; cpu_wdata = cwd;
    dma_addr = da; dma_rd = drd; dma_wr = dwr; dma_wdata = dwd;
    irq_req = irq;
    #1;
    cb = (crd || cwr) ? bus_of(ca, boot_m) : -1;
    db = (drd || dwr) ? bus_of(da, boot_m) : -1;
    for (int b = 0; b < 3; b++) begin
      logic er, ew, ar, aw;
      logic [15:0] ea, aa;
      logic [7:0] ed, ad;
      if (db == b) begin er = drd; ew = dwr; ea = xlat(da); ed = dwd; end
      else if (cb == b) begin er = crd; ew = cwr; ea = xlat(ca); ed = cwd; end
      else begin er = 1'b0; ew = 1'b0; ea = '0; ed = '0; end
      case (b)
        0: begin ar = main_rd; aw = main_wr; aa = main_addr; ad = main_wdata; end
        1: begin ar = vram_rd; aw = vram_wr; aa = {3'b0, vram_addr}; ad = vram_wdata; end
        default: begin ar = oam_rd; aw = oam_wr; aa = {8'b0, oam_addr}; ad = oam_wdata; end
      endcase
      chk({ar, aw} == {er, ew}, tag, $sformatf("bus%0d strobes", b), int'({ar, aw}), int'({er, ew}));
      if (er || ew) chk(aa == ea, tag, $sformatf("bus%0d addr", b), int'(aa), int'(ea));
      if (ew) chk(ad == ed, tag, $sformatf("bus%0d wdata", b), int'(ad), int'(ed));
    end
    is_io = ca >= 16'hFF00 && ca < 16'hFF80 && ca != 16'hFF0F && ca != 16'hFF50;
    chk({io_rd, io_wr} == {crd & is_io, cwr & is_io}, tag, "io strobes",
        int'({io_rd, io_wr}), int'({crd & is_io, cwr & is_io}));
    if (is_io && (crd || cwr)) chk(io_addr == ca[6:0], tag, "io addr", int'(io_addr), int'(ca[6:0]));
    if (crd) begin
      if (cb == 4) exp_c = ca[7:0] ^ 8'h3C;
      else if (cb >= 0 && cb < 3) exp_c = (db == cb) ? 8'hFF : mem_f(cb, xlat(ca));
      else if (ca < 16'hFF00) exp_c = 8'hFF;
      else if (ca == 16'hFF0F) exp_c = {3'b111, if_m};
      else if (ca == 16'hFF50) exp_c = 8'hFF;
      else if (ca < 16'hFF80) exp_c = io_f(ca[6:0]);
      else if (ca == 16'hFFFF) exp_c = ie_m;
      else exp_c = hram_m[ca[6:0]];
    end
    if (drd) begin
      if (db == 4) exp_d = da[7:0] ^ 8'h3C;
      else if (db >= 0 && db < 3) exp_d = mem_f(db, xlat(da));
      else exp_d = 8'hFF;
    end
    if (cwr) begin
      if (ca == 16'hFF50 && cwd != 8'h00) boot_m = 1'b0;
      if (ca >= 16'hFF80 && ca != 16'hFFFF) hram_m[ca[6:0]] = cwd;
      if (ca == 16'hFFFF) ie_m = cwd;
      if (ca == 16'hFF0F) if_m = cwd[4:0];
    end
    if_m = if_m | irq;
    @(negedge clk);
    chk(cpu_rdata == exp_c, tag, "cpu_rdata", int'(cpu_rdata), int'(exp_c));
    chk(dma_rdata == exp_d, tag, "dma_rdata", int'(dma_rdata), int'(exp_d));
    chk(irq_pending == (ie_m[4:0] & if_m), tag, "irq_pending", int'(irq_pending), int'(ie_m[4:0] & if_m));
  endtask

  task automatic crd_t(input logic [15:0] a, input string tag); step(a, 1, 0, 0, 0, 0, 0, 0, 0, tag); endtask
  task automatic cwr_t(input logic [15:0] a, input logic [7:0] d, input string tag); step(a, 0, 1, d, 0, 0, 0, 0, 0, tag); endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    cpu_addr = '0; cpu_rd = 0; cpu_wr = 0; cpu_wdata = '0;
    dma_addr = '0; dma_rd = 0; dma_wr = 0; dma_wdata = '0; irq_req = '0;
    boot_m = 1'b1; if_m = '0; ie_m = '0; exp_c = 8'hFF; exp_d = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cpu_rdata == 8'hFF && dma_rdata == 8'hFF, "R13 reset", "rdata", int'(cpu_rdata), 8'hFF);
    chk(irq_pending == 5'd0, "R12 reset", "irq_pending", int'(irq_pending), 0);
    chk(!(main_rd || main_wr || vram_rd || vram_wr || oam_rd || oam_wr), "R3 reset", "strobes", 0, 0);

    crd_t(16'h0000, "R1 boot low");
    crd_t(16'h00FF, "R1 boot top");
    step(16'h0042, 1, 0, 0, 16'h0010, 1, 0, 0, 0, "R1 R9 boot both masters");
    crd_t(16'h0100, "R3 beyond overlay");
    cwr_t(16'hFF50, 8'h00, "R2 zero write");
    crd_t(16'h0042, "R2 overlay kept");
    cwr_t(16'hFF50, 8'h05, "R2 clear");
    crd_t(16'h0042, "R2 cartridge visible");
    cwr_t(16'hFF50, 8'h00, "R2 rewrite");
    crd_t(16'h0000, "R2 permanent");
    crd_t(16'h8123, "R3 video");
    crd_t(16'hFE9F, "R3 object top");
    crd_t(16'hA005, "R3 cart ram");
    crd_t(16'hC010, "R3 work ram");
    cwr_t(16'h9FFF, 8'hA7, "R3 video write");
    cwr_t(16'hFE00, 8'h3B, "R3 object write");
    crd_t(16'hE010, "R4 echo low");
    cwr_t(16'hFDFF, 8'h61, "R4 echo top");
    for (int i = 0; i < 127; i++) cwr_t(16'hFF80 + 16'(i), 8'(i * 7 + 3), "R5 fill");
    crd_t(16'hFF80, "R5 first");
    crd_t(16'hFFFE, "R5 last");
    crd_t(16'hFFC3, "R5 middle");
    crd_t(16'hFF00, "R6 io low");
    crd_t(16'hFF7F, "R6 io top");
    cwr_t(16'hFF01, 8'h9C, "R6 io write");
    cwr_t(16'hFEA0, 8'h12, "R7 unused write");
    crd_t(16'hFEFF, "R7 unused read");
    crd_t(16'hFEC0, "R7 unused mid");
    step(16'hFE20, 1, 0, 0, 16'hFE10, 0, 1, 8'h44, 0, "R8 object conflict");
    step(16'hC000, 0, 1, 8'h55, 16'hC123, 1, 0, 0, 0, "R8 main write dropped");
    step(16'h8100, 1, 0, 0, 16'hC000, 1, 0, 0, 0, "R8 parallel buses");
    step(16'hE005, 1, 0, 0, 16'hD000, 0, 1, 8'h77, 0, "R8 echo conflict");
    step(16'h0000, 0, 0, 0, 16'hFF80, 1, 0, 0, 0, "R9 dma hram");
    step(16'h0000, 0, 0, 0, 16'hFFFF, 0, 1, 8'hFF, 0, "R9 dma enable write");
    crd_t(16'hFFFF, "R9 R11 enable untouched");
    cwr_t(16'hFFFF, 8'h1F, "R11 enable write");
    step(16'h0000, 0, 0, 0, 16'h0000, 0, 0, 0, 5'b00100, "R10 R12 request");
    crd_t(16'hFF0F, "R10 flag read");
    step(16'hFF0F, 0, 1, 8'h00, 16'h0000, 0, 0, 0, 5'b00001, "R10 write vs request");
    crd_t(16'hFF0F, "R10 flag after race");
    cwr_t(16'hFFFF, 8'h00, "R12 mask off");
    crd_t(16'hFFFF, "R11 enable read");
    step(16'h0000, 0, 0, 0, 16'h0000, 0, 0, 0, 0, "R13 hold");
    step(16'h0000, 0, 0, 0, 16'h0000, 0, 0, 0, 0, "R13 hold again");

    for (int n = 0; n < 2000; n++) begin
      logic [15:0] ca, da;
      logic [1:0] cop, dop;
      int unsigned r;
      r = $urandom;
      case ($urandom % 6)
        0: ca = 16'(r);
        1: ca = 16'hC000 + 16'(r % 32'h2000);
        2: ca = 16'hFF80 + 16'(r % 127);
        3: ca = 16'hFF00 + 16'(r % 128);
        4: ca = 16'h8000 + 16'(r % 32'h2000);
        default: ca = 16'hFE00 + 16'(r % 256);
      endcase
      r = $urandom;
      case ($urandom % 5)
        0: da = 16'(r % 32'h8000);
        1: da = 16'h8000 + 16'(r % 32'h2000);
        2: da = 16'hC000 + 16'(r % 32'h3E00);
        3: da = 16'hFE00 + 16'(r % 160);
        default: da = 16'(r);
      endcase
      cop = 2'($urandom % 3);
      dop = ($urandom % 2 == 0) ? 2'd0 : 2'(1 + $urandom % 2);
      step(ca, cop == 1, cop == 2, 8'($urandom), da, dop == 1, dop == 2, 8'($urandom),
           ($urandom % 4 == 0) ? 5'($urandom) : 5'd0, "R3 R8 R10 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule